// File: doc/BRIEF.md
# Single-to-Double Floating-Point Widening Converter

This block turns a 32-bit IEEE-754 single-precision word into the 64-bit double-precision image that a floating-point register holds after a single-precision load. The conversion is exact, so no rounding takes place. The output is the same number written in the wider format, with the original sign, a rebiased exponent and the fraction padded with zeros on the right.

The input word falls into one of three classes. A normal operand has its 8-bit exponent rebiased by bit replication instead of an adder. The zero, infinity and NaN class is copied with the exponent top bit replicated, which keeps NaN payloads and the quiet bit. A denormal operand is renormalized into a normal double: a leading-zero count over the fraction gives the shift amount, and the exponent falls by one for each shift position.

A parameter chooses between a purely combinational path and one output register stage. With the register stage, the result and its valid strobe appear one clock after the input strobe. A synchronous active-high reset clears the register stage.

Top module: `sp_to_dp_widen`

## Requirements
- R1: For a normal input (exponent field bits 30:23 in 1..254), the result is sign bit 63 = input bit 31, exponent bits 62:52 = input exponent + 896, fraction bits 51:29 = input bits 22:0, and bits 28:0 are zero.
- R2: For an input with exponent field 255 (infinity or any NaN, quiet or signalling), the result exponent is 0x7FF, the sign is copied, and bits 51:29 carry input bits 22:0 unchanged, with bits 28:0 zero.
- R3: For a denormal input (exponent field 0, fraction nonzero) whose highest set fraction bit is at position p (0..22), the result exponent is 874 + p. Bits 51:0 hold the fraction bits below position p, shifted so that bit p-1 lands at bit 51, followed by zeros. The sign is copied.
- R4: An input with both exponent and fraction zero gives a result with only the sign at bit 63 and all other bits zero (+0 and -0).
- R5: With the output register enabled (default), outValid equals the inValid value of the previous clock, and outWord shows that input's result in the same cycle.
- R6: While rst is high at a clock edge, outValid and outWord are cleared to 0 at that edge.
- R7: On a clock where inValid is low, outWord keeps the last result it was loaded with.
- R8: Input 0x42013333 produces 0x4040266660000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input word strobe |
| inWord | input | 32 | Single-precision operand |
| outValid | output | 1 | Result strobe |
| outWord | output | 64 | Double-precision result |

## Verification
Every result in the default configuration is due exactly one rising edge after its input is presented. The bench therefore drives each input on a falling edge and samples outValid and outWord on the next falling edge. At that point it compares them with a reference value that it computes from the numeric widening rule for that input. Cycles with inValid low are checked the same way: outValid must read low and outWord must still show the previous result. Reset is applied while inValid is high, so that the check sees the clearing win over the load.

// File: rtl/widen_pkg.sv
package widen_pkg;
  localparam int SP_W      = 32;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int DP_W      = 64;
  localparam int DP_EXP_W  = 11;
  localparam int DP_FRAC_W = 52;
  localparam int SP_BIAS   = (1 << (SP_EXP_W - 1)) - 1;
  localparam int DP_BIAS   = (1 << (DP_EXP_W - 1)) - 1;
  localparam int PAD_W     = DP_FRAC_W - SP_FRAC_W;
  localparam int REPL_W    = DP_EXP_W - SP_EXP_W;
  localparam int LZC_W     = $clog2(SP_FRAC_W + 1) + 1;
  // exponent of a denormal before renormalizing, in double bias
  localparam int DENORM_BASE = DP_BIAS - (SP_BIAS - 1);

  typedef enum logic [1:0] {
    CLS_NORMAL  = 2'd0,
    CLS_DENORM  = 2'd1,
    CLS_SPECIAL = 2'd2
  } opClass_t;

  typedef struct packed {
    logic loadEn;
    logic clear;
  } widenStrobes_t;
endpackage

// File: rtl/widen_classify.sv
module widen_classify
  import widen_pkg::*;
(
  input  logic [SP_EXP_W-1:0]  expIn,
  input  logic [SP_FRAC_W-1:0] fracIn,
  output opClass_t             cls
);
  logic expAllOnes;
  logic expZero;
  logic fracZero;

  assign expAllOnes = &expIn;
  assign expZero    = ~|expIn;
  assign fracZero   = ~|fracIn;

  // zero/inf/NaN first, then denormal, then normal
  always_comb begin
    if (expAllOnes || (expZero && fracZero)) cls = CLS_SPECIAL;
    else if (expZero)                        cls = CLS_DENORM;
    else                                     cls = CLS_NORMAL;
  end
endmodule

// File: rtl/widen_lzc.sv
module widen_lzc #(
  parameter int W     = 23,
  parameter int CNT_W = $clog2(W + 1) + 1
) (
  input  logic [W-1:0]     vec,
  output logic [CNT_W-1:0] count
);
  always_comb begin
    count = CNT_W'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) count = CNT_W'(W - 1 - i);
    end
  end
endmodule

// File: rtl/widen_datapath.sv
module widen_datapath
  import widen_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  widenStrobes_t     strb,
  input  logic [SP_W-1:0]   inWord,
  output logic [DP_W-1:0]   outWord
);
  logic                  sgn;
  logic [SP_EXP_W-1:0]   expIn;
  logic [SP_FRAC_W-1:0]  fracIn;
  opClass_t              cls;
  logic [LZC_W-1:0]      lzCount;
  logic [LZC_W-1:0]      shiftAmt;
  logic [SP_FRAC_W-1:0]  shiftedFrac;
  logic [DP_EXP_W-1:0]   denExp;
  logic [DP_W-1:0]       nextWord;

  assign sgn    = inWord[SP_W-1];
  assign expIn  = inWord[SP_W-2 -: SP_EXP_W];
  assign fracIn = inWord[SP_FRAC_W-1:0];

  widen_classify classify_i (
    .expIn  (expIn),
    .fracIn (fracIn),
    .cls    (cls)
  );

  widen_lzc #(.W(SP_FRAC_W), .CNT_W(LZC_W)) lzc_i (
    .vec   (fracIn),
    .count (lzCount)
  );

  assign shiftAmt    = lzCount + LZC_W'(1);
  assign shiftedFrac = fracIn << shiftAmt;
  assign denExp      = DP_EXP_W'(DENORM_BASE) - DP_EXP_W'(shiftAmt);

  always_comb begin
    unique case (cls)
      CLS_SPECIAL: nextWord = {sgn, expIn[SP_EXP_W-1], {REPL_W{expIn[SP_EXP_W-1]}},
                               inWord[SP_W-3:0], {PAD_W{1'b0}}};
      CLS_DENORM:  nextWord = {sgn, denExp, shiftedFrac, {PAD_W{1'b0}}};
      default:     nextWord = {sgn, expIn[SP_EXP_W-1], {REPL_W{~expIn[SP_EXP_W-1]}},
                               inWord[SP_W-3:0], {PAD_W{1'b0}}};
    endcase
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (strb.clear)       outWord <= '0;
        else if (strb.loadEn) outWord <= nextWord;
      end

      assert_hold_R7: assert property (@(posedge clk) disable iff (strb.clear)
        !strb.loadEn |=> $stable(outWord));
    end else begin : g_comb
      assign outWord = nextWord;
    end
  endgenerate

  // replication must agree with an additive rebias
  assert_normal_rebias_R1: assert property (@(posedge clk) disable iff (strb.clear)
    (cls == CLS_NORMAL) |->
      (nextWord[DP_W-2 -: DP_EXP_W] == DP_EXP_W'(expIn) + DP_EXP_W'(DP_BIAS - SP_BIAS)));

  assert_special_exp_R2: assert property (@(posedge clk) disable iff (strb.clear)
    (&expIn) |-> (&nextWord[DP_W-2 -: DP_EXP_W]));

  assert_denorm_exp_range_R3: assert property (@(posedge clk) disable iff (strb.clear)
    (cls == CLS_DENORM) |->
      (nextWord[DP_W-2 -: DP_EXP_W] >= DP_EXP_W'(DENORM_BASE - SP_FRAC_W) &&
       nextWord[DP_W-2 -: DP_EXP_W] <= DP_EXP_W'(DENORM_BASE - 1)));

  assert_zero_R4: assert property (@(posedge clk) disable iff (strb.clear)
    (inWord[SP_W-2:0] == '0) |-> (nextWord[DP_W-2:0] == '0));
endmodule

// File: rtl/widen_ctrl.sv
module widen_ctrl
  import widen_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  output widenStrobes_t strb,
  output logic          outValid
);
  assign strb.loadEn = inValid;
  assign strb.clear  = rst;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) outValid <= 1'b0;
        else     outValid <= inValid;
      end

      assert_valid_follows_R5: assert property (@(posedge clk) disable iff (rst)
        inValid |=> outValid);
      assert_valid_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !inValid |=> !outValid);
      assert_reset_clear_R6: assert property (@(posedge clk)
        rst |=> !outValid);
    end else begin : g_comb
      assign outValid = inValid;
    end
  endgenerate
endmodule

// File: rtl/sp_to_dp_widen.sv
module sp_to_dp_widen
  import widen_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  input  logic [SP_W-1:0] inWord,
  output logic            outValid,
  output logic [DP_W-1:0] outWord
);
  widenStrobes_t strb;

  widen_ctrl #(.REG_OUT(REG_OUT)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strb     (strb),
    .outValid (outValid)
  );

  widen_datapath #(.REG_OUT(REG_OUT)) dp_i (
    .clk     (clk),
    .strb    (strb),
    .inWord  (inWord),
    .outWord (outWord)
  );
endmodule

// File: tb/sp_to_dp_widen_tb.sv
`timescale 1ns/1ps
module sp_to_dp_widen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [31:0] inWord = '0;
  logic        outValid;
  logic [63:0] outWord;

  int checks = 0;
  int errors = 0;
  logic [63:0] lastResult = '0;

  always #4 clk = ~clk;

  sp_to_dp_widen dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inWord(inWord),
    .outValid(outValid), .outWord(outWord)
  );

  // numeric widening rule
  function automatic logic [63:0] refWiden(input logic [31:0] w);
    logic        s;
    int          e;
    logic [22:0] f;
    logic [63:0] r;
    int          msb;
    s = w[31]; e = int'(w[30:23]); f = w[22:0];
    if (e == 255) begin
      r = {s, 11'h7FF, f, 29'd0};
    end else if (e == 0 && f == 0) begin
      r = {s, 63'd0};
    end else if (e == 0) begin
      msb = 0;
      for (int i = 0; i < 23; i++) if (f[i]) msb = i;
      r = '0;
      r[63] = s;
      r[62:52] = 11'(874 + msb);
      r[51:0] = (52'(f) & ~(52'd1 << msb)) << (52 - msb);
    end else begin
      r = {s, 11'(e - 127 + 1023), f, 29'd0};
    end
    return r;
  endfunction

  task automatic checkVal(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, sample one edge later at the next negedge
  task automatic step(input logic v, input logic [31:0] w, input string tag);
    logic [63:0] exp;
    inValid = v;
    inWord  = w;
    exp = v ? refWiden(w) : lastResult;
    @(negedge clk);
    checkVal({tag, " R5 valid"}, 64'(outValid), 64'(v));
    checkVal(v ? tag : {tag, " R7 hold"}, outWord, exp);
    lastResult = exp;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    inValid = 1'b1; inWord = 32'h3F800000;
    @(negedge clk); @(negedge clk);
    checkVal("R6 reset valid", 64'(outValid), 64'd0);
    checkVal("R6 reset word", outWord, 64'd0);
    rst = 1'b0; inValid = 1'b0;
    @(negedge clk);

    step(1, 32'h42013333, "R8 example");
    checkVal("R8 literal", outWord, 64'h4040266660000000);
    step(0, 32'h12345678, "R7 idle");
    step(1, 32'h00000000, "R4 +0");
    step(1, 32'h80000000, "R4 -0");
    step(1, 32'h7F800000, "R2 +inf");
    step(1, 32'hFF800000, "R2 -inf");
    step(1, 32'h7FC00001, "R2 qnan");
    step(1, 32'h7F800001, "R2 snan");
    step(1, 32'h00000001, "R3 min denorm");
    checkVal("R3 min denorm literal", outWord, {1'b0, 11'd874, 52'd0});
    step(1, 32'h807FFFFF, "R3 max denorm");
    step(1, 32'h00400000, "R3 top-bit denorm");
    step(1, 32'h00012345, "R3 mid denorm");
    step(1, 32'h00800000, "R1 min normal");
    step(1, 32'h7F7FFFFF, "R1 max normal");
    step(1, 32'hBF800000, "R1 -1.0");
    step(0, 32'hFFFFFFFF, "R7 idle2");
    step(0, 32'h00000000, "R7 idle3");

    for (int i = 0; i < 200; i++) begin
      logic [31:0] w;
      w = $urandom;
      w[30:23] = 8'(1 + ($urandom % 254));
      step(1, w, "R1 random normal");
    end
    for (int i = 0; i < 50; i++) begin
      logic [31:0] w;
      w = $urandom;
      w[30:23] = 8'd0;
      if (w[22:0] == 0) w[0] = 1'b1;
      step(1, w, "R3 random denorm");
    end

    inValid = 1'b1; inWord = 32'h40490FDB; rst = 1'b1;
    @(negedge clk);
    checkVal("R6 mid reset valid", 64'(outValid), 64'd0);
    checkVal("R6 mid reset word", outWord, 64'd0);
    rst = 1'b0; lastResult = '0;
    step(1, 32'h40490FDB, "R1 after reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule